// File: doc/BRIEF.md
# Segmented Pipelined Adder/Subtractor

This block adds or subtracts two signed operands whose widths are set independently by parameters. Instead of one long carry chain, the operation is cut into 12-bit slices. Each slice gets its own register stage, and the carry out of one slice's stage feeds the next slice's stage one cycle later. Clock timing therefore depends on one slice and never on the full operand width. The block is used wherever a wide sum must close timing at a high clock rate and the surrounding pipeline can work out its own delay-line depth from the operand widths alone.

Before slicing, the narrower operand is sign-extended to the wider width. The result is one bit wider than the wider operand, so it never overflows. Subtraction is formed as A plus the inverted B plus a carry. The carry input is enabled by default (parameter `USE_CIN`):

- In add mode, the carry input adds one.
- In subtract mode, the carry input works as an active-low borrow: driven low, it takes one extra from the difference.
- With the carry input disabled, add mode uses a carry of zero and subtract mode uses a carry of one.

Skew registers delay each operand slice so that it reaches its stage in step with the incoming carry. Deskew registers then line up all finished slices. A new operand pair can be accepted on every cycle. A valid flag runs alongside the data and marks each result.

Top module: `segadd_pipe`

## Requirements
- R1: The result for a pair presented with `inValid` high is on `result` with `outValid` high exactly ceil(max(WIDTH_A, WIDTH_B)/12) rising edges later.
- R2: `outValid` is low during reset and for the cycles after it until the first result is due. It is high only on cycles that carry the result of an accepted pair.
- R3: With `subtract` low (0 = add) and `carryIn` low, `result` equals sext(A) + sext(B), written as a two's-complement value max(WIDTH_A, WIDTH_B)+1 bits wide.
- R4: With `subtract` high (1 = subtract) and `carryIn` high, `result` equals sext(A) − sext(B).
- R5: With `subtract` low and `carryIn` high, `result` equals sext(A) + sext(B) + 1.
- R6: With `subtract` high and `carryIn` low, `result` equals sext(A) − sext(B) − 1.
- R7: When the widths differ, the narrower operand is treated as signed and sign-extended, so a negative narrow operand gives the correct signed result.
- R8: Carries cross every 12-bit slice boundary and reach the top result bit, for example 4095 + 1 = 4096 and (2^24 − 1) + 1 = 2^24.
- R9: A pair may be presented on every cycle. Back-to-back pairs each produce their own correct result on consecutive cycles, in order.
- R10: The latency is the same in both modes and for both levels of `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a pair to be processed this cycle |
| subtract | input | 1 | 0 = add, 1 = subtract |
| carryIn | input | 1 | Carry in (add) or active-low borrow (subtract) |
| opA | input | WIDTH_A | Operand A, signed |
| opB | input | WIDTH_B | Operand B, signed |
| outValid | output | 1 | Marks a result on `result` |
| result | output | max(WIDTH_A,WIDTH_B)+1 | Signed sum or difference |

## Verification
The assertions assume that `inValid` and the operand pins hold settled, known values at every rising edge after reset. They also assume that no more pairs are in flight than there are pipeline stages. The bench meets both conditions by changing inputs only on falling edges and by driving known values on every cycle, including idle ones. The bench uses a 26-bit by 9-bit configuration. It sweeps every value of the narrow operand against a set of boundary values of the wide one, in all four mode and carry combinations. It then adds long random back-to-back bursts, so all three slices and both boundaries between them are exercised.

// File: rtl/segadd_pkg.sv
package segadd_pkg;

  // Per-cycle control handed from the control unit to the datapath.
  typedef struct packed {
    logic invB;    // invert operand B before slicing (subtract)
    logic carry0;  // carry injected into the lowest slice
  } segStrobe_t;

  function automatic int maxOf(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int ceilDiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

endpackage

// File: rtl/segadd_ctrl.sv
module segadd_ctrl
  import segadd_pkg::*;
#(
  parameter int LAT     = 3,
  parameter bit USE_CIN = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       subtract,
  input  logic       carryIn,
  output segStrobe_t strobe,
  output logic       outValid
);

  logic [LAT-1:0] vldQ;

  // Mode decode: subtract inverts B; the carry pin replaces the constant 1.
  always_comb begin
    strobe.invB   = subtract;
    strobe.carry0 = (USE_CIN != 1'b0) ? carryIn : subtract;
  end

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vldQ <= '0;
        else       vldQ <= inValid;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vldQ <= '0;
        else       vldQ <= {vldQ[LAT-2:0], inValid};
      end
    end
  endgenerate

  assign outValid = vldQ[LAT-1];

  // Checker bookkeeping: edges since reset and pairs in flight.
  logic [15:0] sinceRst;
  logic [15:0] pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      pending  <= '0;
    end else begin
      if (sinceRst != 16'hFFFF) sinceRst <= sinceRst + 16'd1;
      pending <= pending + {15'd0, inValid} - {15'd0, outValid};
    end
  end

  // R1
  early_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 16'(LAT)) |-> !outValid);

  // R1
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending <= 16'(LAT));

  // R2
  orphan_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pending != 16'd0));

endmodule

// File: rtl/segadd_datapath.sv
module segadd_datapath
  import segadd_pkg::*;
#(
  parameter int WIDTH_A = 26,
  parameter int WIDTH_B = 9,
  parameter int SEG_W   = 12
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  segStrobe_t                            strobe,
  input  logic [WIDTH_A-1:0]                    opA,
  input  logic [WIDTH_B-1:0]                    opB,
  output logic [maxOf(WIDTH_A, WIDTH_B):0]      result
);

  localparam int WMAX = maxOf(WIDTH_A, WIDTH_B);
  localparam int EXTW = WMAX + 1;
  localparam int NSEG = ceilDiv(WMAX, SEG_W);

  logic [EXTW-1:0] aExt;
  logic [EXTW-1:0] bExt;
  logic [EXTW-1:0] bOp;

  assign aExt = {{(EXTW - WIDTH_A){opA[WIDTH_A-1]}}, opA};
  assign bExt = {{(EXTW - WIDTH_B){opB[WIDTH_B-1]}}, opB};
  assign bOp  = strobe.invB ? ~bExt : bExt;

  generate
    for (genvar k = 0; k < NSEG; k++) begin : seg
      localparam int LO   = k * SEG_W;
      localparam int SW   = (k == NSEG - 1) ? (EXTW - LO) : SEG_W;
      localparam int TAIL = NSEG - 1 - k;

      logic [SW-1:0] aDly [0:k];
      logic [SW-1:0] bDly [0:k];
      logic          cin;
      logic [SW-1:0] sumQ;
      logic [SW-1:0] outDly [0:TAIL];

      // Input skew: slice k waits k cycles for its carry.
      assign aDly[0] = aExt[LO +: SW];
      assign bDly[0] = bOp[LO +: SW];

      for (genvar i = 1; i <= k; i++) begin : skew
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            aDly[i] <= '0;
            bDly[i] <= '0;
          end else begin
            aDly[i] <= aDly[i-1];
            bDly[i] <= bDly[i-1];
          end
        end
      end

      if (k == 0) begin : cFirst
        assign cin = strobe.carry0;
      end else begin : cChain
        assign cin = seg[k-1].mid.carryQ;
      end

      if (k < NSEG - 1) begin : mid
        logic [SW:0] wide;
        logic        carryQ;

        assign wide = {1'b0, aDly[k]} + {1'b0, bDly[k]} + {{SW{1'b0}}, cin};

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sumQ   <= '0;
            carryQ <= 1'b0;
          end else begin
            sumQ   <= wide[SW-1:0];
            carryQ <= wide[SW];
          end
        end

        if (k == 0) begin : wrapChk
          // R8
          seg_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
            (cin && ((aDly[0] ^ bDly[0]) == {SW{1'b1}})) |=> ((sumQ == '0) && carryQ));
        end
      end else begin : last
        logic [SW-1:0] narrow;

        assign narrow = aDly[k] + bDly[k] + {{(SW-1){1'b0}}, cin};

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) sumQ <= '0;
          else       sumQ <= narrow;
        end
      end

      if (k == 0) begin : zeroChk
        // R3
        zero_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
          ((aDly[0] == '0) && (bDly[0] == '0) && !cin) |=> (sumQ == '0));
      end

      // Output deskew: finished slices wait for the top slice.
      assign outDly[0] = sumQ;

      for (genvar i = 1; i <= TAIL; i++) begin : deskew
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) outDly[i] <= '0;
          else       outDly[i] <= outDly[i-1];
        end
      end

      assign result[LO +: SW] = outDly[TAIL];
    end
  endgenerate

endmodule

// File: rtl/segadd_pipe.sv
module segadd_pipe
  import segadd_pkg::*;
#(
  parameter int WIDTH_A = 26,
  parameter int WIDTH_B = 9,
  parameter int SEG_W   = 12,
  parameter bit USE_CIN = 1'b1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic                               subtract,
  input  logic                               carryIn,
  input  logic [WIDTH_A-1:0]                 opA,
  input  logic [WIDTH_B-1:0]                 opB,
  output logic                               outValid,
  output logic [maxOf(WIDTH_A, WIDTH_B):0]   result
);

  localparam int WMAX = maxOf(WIDTH_A, WIDTH_B);
  localparam int LAT  = ceilDiv(WMAX, SEG_W);

  segStrobe_t strobe;

  segadd_ctrl #(
    .LAT     (LAT),
    .USE_CIN (USE_CIN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .subtract (subtract),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .outValid (outValid)
  );

  segadd_datapath #(
    .WIDTH_A (WIDTH_A),
    .WIDTH_B (WIDTH_B),
    .SEG_W   (SEG_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/sim_segadd_pipe.sv
`timescale 1ns/1ps
module sim_segadd_pipe;

  localparam int WA  = 26;
  localparam int WB  = 9;
  localparam int WM  = (WA > WB) ? WA : WB;
  localparam int LAT = (WM + 11) / 12;

  typedef struct {
    logic          vld;
    logic [WM:0]   exp;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          subtract = 1'b0;
  logic          carryIn = 1'b0;
  logic [WA-1:0] opA = '0;
  logic [WB-1:0] opB = '0;
  logic          outValid;
  logic [WM:0]   result;

  int total = 0;
  int bad = 0;
  int stepNo = 0;
  int seenAt = -1;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  segadd_pipe #(.WIDTH_A(WA), .WIDTH_B(WB), .SEG_W(12), .USE_CIN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .subtract(subtract),
    .carryIn(carryIn), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [WM:0] model(input logic [WA-1:0] a, input logic [WB-1:0] b,
                                         input logic sub, input logic cin);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint r;
    logic [63:0] rv;
    if (sub) r = sa - sb - (cin ? 64'sd0 : 64'sd1);
    else     r = sa + sb + (cin ? 64'sd1 : 64'sd0);
    rv = r;
    return rv[WM:0];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (step %0d)", tag, act, exp, stepNo);
    end
  endtask

  // One cycle: compare the due result, then drive the next inputs.
  task automatic step(input logic v, input logic sub, input logic cin,
                      input logic [WA-1:0] a, input logic [WB-1:0] b, input string tag);
    expItem_t it;
    @(negedge clk);
    stepNo++;
    if (outValid) seenAt = stepNo;
    if (expQ.size() == LAT) begin
      it = expQ.pop_front();
      check(outValid == it.vld, "R2", longint'(outValid), longint'(it.vld));
      if (it.vld) check(result == it.exp, it.tag, longint'(result), longint'(it.exp));
    end
    inValid  = v;
    subtract = sub;
    carryIn  = cin;
    opA      = a;
    opB      = b;
    it.vld = v;
    it.exp = model(a, b, sub, cin);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "R2");
  endtask

  // R1 / R10: count steps from a lone pair to its valid result.
  task automatic measure(input logic sub, input logic cin, input string tag);
    int s0;
    idle(LAT + 2);
    seenAt = -1;
    step(1'b1, sub, cin, 26'd1234567, 9'd77, tag);
    s0 = stepNo;
    idle(LAT + 2);
    check(seenAt - s0 == LAT, tag, longint'(seenAt - s0), longint'(LAT));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [WA-1:0] corners [10];
    corners[0] = 26'd0;
    corners[1] = 26'd1;
    corners[2] = '1;                         // -1
    corners[3] = 26'h1FF_FFFF;               // max positive
    corners[4] = 26'h200_0000;               // min negative
    corners[5] = 26'd4095;
    corners[6] = 26'd4096;
    corners[7] = 26'hFF_FFFF;
    corners[8] = 26'h3FF_F000;
    corners[9] = 26'h155_5555;

    // R2: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R2", longint'(outValid), 0);
    check(result == '0, "R2", longint'(result), 0);
    rstN = 1'b1;
    idle(LAT + 1);

    // R1, R10: latency in all mode and carry combinations
    measure(1'b0, 1'b0, "R1");
    measure(1'b1, 1'b1, "R10");
    measure(1'b0, 1'b1, "R10");
    measure(1'b1, 1'b0, "R10");

    // R8: carries across slice boundaries and into the top bit
    step(1'b1, 1'b0, 1'b0, 26'd4095, 9'd1, "R8");
    step(1'b1, 1'b0, 1'b0, 26'hFF_FFFF, 9'd1, "R8");
    step(1'b1, 1'b0, 1'b0, 26'h1FF_FFFF, 9'd1, "R8");
    step(1'b1, 1'b0, 1'b1, 26'h1FF_FFFF, 9'h0FF, "R8");
    step(1'b1, 1'b1, 1'b1, 26'd4096, 9'd1, "R8");
    step(1'b1, 1'b1, 1'b0, 26'h200_0000, 9'h0FF, "R8");
    idle(LAT);

    // R7: negative narrow operand against positive wide one
    step(1'b1, 1'b0, 1'b0, 26'd5, 9'h1FF, "R7");
    step(1'b1, 1'b0, 1'b0, 26'd300, 9'h100, "R7");
    step(1'b1, 1'b1, 1'b1, 26'd0, 9'h100, "R7");
    idle(LAT);

    // R3..R6: narrow operand swept exhaustively against wide corners
    for (int c = 0; c < 10; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int b = 0; b < (1 << WB); b++) begin
          case (m)
            0: step(1'b1, 1'b0, 1'b0, corners[c], WB'(b), "R3");
            1: step(1'b1, 1'b1, 1'b1, corners[c], WB'(b), "R4");
            2: step(1'b1, 1'b0, 1'b1, corners[c], WB'(b), "R5");
            default: step(1'b1, 1'b1, 1'b0, corners[c], WB'(b), "R6");
          endcase
        end
      end
    end
    idle(LAT);

    // R9: random back-to-back bursts with gaps
    for (int n = 0; n < 6000; n++) begin
      logic v;
      v = ($urandom_range(0, 7) != 0);
      step(v, 1'(($urandom >> 3) & 1), 1'(($urandom >> 5) & 1),
           WA'($urandom), WB'($urandom), "R9");
    end
    idle(LAT + 2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule